// File: doc/BRIEF.md
# Flag Offset Programmer

This block holds the two threshold offsets that a FIFO's flag logic compares against: the almost-empty distance and the almost-full distance. Each offset is 18 bits, stored as a 9-bit low half and a 9-bit high half. That gives four internal half-registers, visited in a fixed order: empty-low (slot 0), empty-high (slot 1), full-low (slot 2), full-high (slot 3), then back to empty-low. Software or a board-level controller programs these halves through one of two methods. The method is chosen once, while master reset is held.

In parallel mode, a cycle with `load` and `wr_en` high writes `pdata_in` into the slot picked by the write pointer, and the write pointer then steps to the next slot. In serial mode, each cycle with `ser_en` high shifts one bit of `ser_din` into the current slot, least-significant bit first. After nine bits the write pointer moves to the next slot. In either mode, a cycle with `load` and `rd_en` high copies the slot picked by the separate read pointer onto `pdata_out` and steps that pointer. A cycle that asks for both a read and a write is refused and reported on `access_err`.

A small controller state machine sequences the block. Its states are:
- `ST_HOLD`: entered on every master-reset cycle. It accepts no access.
- `ST_PAR`: parallel mode.
- `ST_SER`: serial mode.

Its transitions are:
- master reset from any state goes to `ST_HOLD`.
- `ST_HOLD` with reset released goes to `ST_SER` if serial mode was latched, otherwise to `ST_PAR`.
- `ST_PAR` and `ST_SER` stay where they are until the next master reset.

Top module: `ofs_flag_prog`

## Requirements
- R1: A cycle with `rst_mst` high sets `ae_offset` to 18'h0007F and `af_offset` to 18'h001FF (parameter defaults), clears `pdata_out` and both pointers (and the serial bit position), and keeps `access_err` low.
- R2: The programming method is the value of `mode_ser_sel` in the last master-reset cycle (1 = serial, 0 = parallel). Changing `mode_ser_sel` afterwards has no effect.
- R3: In the first cycle after `rst_mst` falls, no read, write or serial shift is accepted.
- R4: In parallel mode, `load`=1, `wr_en`=1, `rd_en`=0 stores `pdata_in` into the slot at the write pointer. The pointer then advances in the order slot 0, 1, 2, 3, 0. `ae_offset` = {slot1, slot0} and `af_offset` = {slot3, slot2}.
- R5: `load`=1, `rd_en`=1, `wr_en`=0 places the slot at the read pointer (its value before that edge) on `pdata_out` at the next edge, and advances the read pointer in the same order. Otherwise `pdata_out` holds its value.
- R6: The read and write pointers move only on their own accesses and never affect each other.
- R7: In serial mode, each cycle with `ser_en`=1 writes `ser_din` into bit b of the slot at the write pointer, with b running 0 to 8. After bit 8 the write pointer advances to the next slot. Exactly one bit of the offsets can change per shift.
- R8: Parallel writes are ignored in serial mode, and `ser_en` is ignored in parallel mode. Parallel reads work in both modes.
- R9: When `load`, `wr_en` and `rd_en` are all high in an active state (not reset, not partial reset, not `ST_HOLD`), `access_err` is high in that same cycle. Neither pointer moves, no slot is written, and `pdata_out` is unchanged. A serial shift in that cycle still proceeds.
- R10: While `rst_part` is high, no access of any kind is accepted: offsets, pointers and `pdata_out` are unchanged, and `access_err` stays low.
- R11: A master reset in the middle of a serial or parallel sequence restarts the writes at bit 0 of slot 0 and the reads at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_mst | input | 1 | Synchronous master reset, active high |
| rst_part | input | 1 | Partial reset, active high; holds off all accesses |
| mode_ser_sel | input | 1 | Programming method sampled during master reset (1 = serial) |
| ser_en | input | 1 | Serial shift enable |
| ser_din | input | 1 | Serial data bit |
| load | input | 1 | Qualifies parallel reads and writes |
| wr_en | input | 1 | Parallel write request |
| rd_en | input | 1 | Parallel read request |
| pdata_in | input | 9 | Parallel write data |
| ae_offset | output | 18 | Almost-empty offset to flag logic |
| af_offset | output | 18 | Almost-full offset to flag logic |
| pdata_out | output | 9 | Registered read-back data |
| access_err | output | 1 | Read and write requested together, access refused |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- the reset values;
- that a refused cycle, a partial-reset cycle or a cycle without a read leaves the read-back bus and offsets untouched;
- that a serial shift flips at most one offset bit;
- that a parallel write touches at most one half.

Only the bench's scenarios can show that the pointers follow the slot order and wrap, that the read and write pointers stay independent across long interleaved sequences, that bits land LSB first in the right slot, and that the method latched at master reset survives later changes of the select pin.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

    // Slot order is behavioural: both pointers walk it and wrap.
    typedef enum logic [1:0] {
        SLOT_E_LO = 2'd0,
        SLOT_E_HI = 2'd1,
        SLOT_F_LO = 2'd2,
        SLOT_F_HI = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_PAR  = 2'd1,
        ST_SER  = 2'd2
    } ctl_state_e;

    localparam int NUM_SLOTS = 4;

    function automatic slot_e next_slot(input slot_e cur);
        return slot_e'(cur + 2'd1);
    endfunction

endpackage

// File: rtl/ofs_access_ctl.sv
module ofs_access_ctl
    import ofs_prog_pkg::*;
(
    input  logic clk,
    input  logic rst_mst,
    input  logic rst_part,
    input  logic mode_ser_sel,
    input  logic load,
    input  logic wr_en,
    input  logic rd_en,
    input  logic ser_en,
    output logic par_wr_go,
    output logic par_rd_go,
    output logic ser_go,
    output logic access_err
);

    ctl_state_e state_q;
    ctl_state_e state_d;
    logic       mode_ser_q;
    logic       open_win;
    logic       want_wr;
    logic       want_rd;
    logic       clash;

    // State register and mode latch.
    always_ff @(posedge clk) begin
        if (rst_mst) begin
            state_q    <= ST_HOLD;
            mode_ser_q <= mode_ser_sel;
        end else begin
            state_q    <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = mode_ser_q ? ST_SER : ST_PAR;
            ST_PAR:  state_d = ST_PAR;
            ST_SER:  state_d = ST_SER;
            default: state_d = ST_HOLD;
        endcase
    end

    assign open_win = !rst_mst && !rst_part;
    assign clash    = load && wr_en && rd_en;
    assign want_wr  = load && wr_en && !rd_en;
    assign want_rd  = load && rd_en && !wr_en;

    // Output decode.
    always_comb begin
        par_wr_go  = 1'b0;
        par_rd_go  = 1'b0;
        ser_go     = 1'b0;
        access_err = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                par_wr_go = 1'b0;
            end
            ST_PAR: begin
                par_wr_go  = open_win && want_wr;
                par_rd_go  = open_win && want_rd;
                access_err = open_win && clash;
            end
            ST_SER: begin
                ser_go     = open_win && ser_en;
                par_rd_go  = open_win && want_rd;
                access_err = open_win && clash;
            end
            default: begin
                par_wr_go = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ofs_slot_ptr.sv
module ofs_slot_ptr
    import ofs_prog_pkg::*;
#(
    parameter int HALF_W  = 9,
    parameter bit BITWISE = 1'b0,
    localparam int BIT_W  = (HALF_W > 1) ? $clog2(HALF_W) : 1
)(
    input  logic             clk,
    input  logic             rst_mst,
    input  logic             adv_word,
    input  logic             adv_bit,
    output slot_e            slot,
    output logic [BIT_W-1:0] bit_idx
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(HALF_W - 1);

    logic step;

    generate
        if (BITWISE) begin : g_bitwise
            logic [BIT_W-1:0] bit_q;
            always_ff @(posedge clk) begin
                if (rst_mst) begin
                    bit_q <= '0;
                end else if (adv_bit) begin
                    bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
                end
            end
            assign bit_idx = bit_q;
            assign step    = adv_word || (adv_bit && (bit_q == LAST_BIT));
        end else begin : g_wordwise
            // Without a bit counter, both inputs are whole-slot steps.
            assign bit_idx = '0;
            assign step    = adv_word || adv_bit;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst_mst) begin
            slot <= SLOT_E_LO;
        end else if (step) begin
            slot <= next_slot(slot);
        end
    end

endmodule

// File: rtl/ofs_reg_bank.sv
module ofs_reg_bank
    import ofs_prog_pkg::*;
#(
    parameter int HALF_W = 9,
    parameter logic [2*HALF_W-1:0] DEF_EMPTY_OFS = 'h0007F,
    parameter logic [2*HALF_W-1:0] DEF_FULL_OFS  = 'h001FF,
    localparam int BIT_W = (HALF_W > 1) ? $clog2(HALF_W) : 1,
    localparam int OFS_W = 2 * HALF_W
)(
    input  logic              clk,
    input  logic              rst_mst,
    input  logic              par_wr_go,
    input  logic              par_rd_go,
    input  logic              ser_go,
    input  logic              ser_din,
    input  slot_e             wr_slot,
    input  logic [BIT_W-1:0]  wr_bit,
    input  slot_e             rd_slot,
    input  logic [HALF_W-1:0] pdata_in,
    output logic [OFS_W-1:0]  ae_offset,
    output logic [OFS_W-1:0]  af_offset,
    output logic [HALF_W-1:0] pdata_out
);

    logic [HALF_W-1:0] half_q [NUM_SLOTS];

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_half
            localparam logic [OFS_W-1:0]  DEF_WORD = (g < 2) ? DEF_EMPTY_OFS : DEF_FULL_OFS;
            localparam logic [HALF_W-1:0] DEF_HALF = (g % 2 == 0) ? DEF_WORD[HALF_W-1:0]
                                                                  : DEF_WORD[OFS_W-1:HALF_W];
            logic sel;
            assign sel = (wr_slot == slot_e'(g));
            always_ff @(posedge clk) begin
                if (rst_mst) begin
                    half_q[g] <= DEF_HALF;
                end else if (par_wr_go && sel) begin
                    half_q[g] <= pdata_in;
                end else if (ser_go && sel) begin
                    half_q[g][wr_bit] <= ser_din;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst_mst) begin
            pdata_out <= '0;
        end else if (par_rd_go) begin
            pdata_out <= half_q[rd_slot];
        end
    end

    assign ae_offset = {half_q[SLOT_E_HI], half_q[SLOT_E_LO]};
    assign af_offset = {half_q[SLOT_F_HI], half_q[SLOT_F_LO]};

endmodule

// File: rtl/ofs_flag_prog.sv
module ofs_flag_prog
    import ofs_prog_pkg::*;
#(
    parameter int HALF_W = 9,
    parameter logic [2*HALF_W-1:0] DEF_EMPTY_OFS = 'h0007F,
    parameter logic [2*HALF_W-1:0] DEF_FULL_OFS  = 'h001FF,
    localparam int OFS_W = 2 * HALF_W,
    localparam int BIT_W = (HALF_W > 1) ? $clog2(HALF_W) : 1
)(
    input  logic              clk,
    input  logic              rst_mst,
    input  logic              rst_part,
    input  logic              mode_ser_sel,
    input  logic              ser_en,
    input  logic              ser_din,
    input  logic              load,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [HALF_W-1:0] pdata_in,
    output logic [OFS_W-1:0]  ae_offset,
    output logic [OFS_W-1:0]  af_offset,
    output logic [HALF_W-1:0] pdata_out,
    output logic              access_err
);

    logic             par_wr_go;
    logic             par_rd_go;
    logic             ser_go;
    slot_e            wr_slot;
    slot_e            rd_slot;
    logic [BIT_W-1:0] wr_bit;
    logic [BIT_W-1:0] rd_bit_unused;

    ofs_access_ctl u_ctl (
        .clk          (clk),
        .rst_mst      (rst_mst),
        .rst_part     (rst_part),
        .mode_ser_sel (mode_ser_sel),
        .load         (load),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .ser_en       (ser_en),
        .par_wr_go    (par_wr_go),
        .par_rd_go    (par_rd_go),
        .ser_go       (ser_go),
        .access_err   (access_err)
    );

    ofs_slot_ptr #(.HALF_W(HALF_W), .BITWISE(1'b1)) u_wr_ptr (
        .clk      (clk),
        .rst_mst  (rst_mst),
        .adv_word (par_wr_go),
        .adv_bit  (ser_go),
        .slot     (wr_slot),
        .bit_idx  (wr_bit)
    );

    ofs_slot_ptr #(.HALF_W(HALF_W), .BITWISE(1'b0)) u_rd_ptr (
        .clk      (clk),
        .rst_mst  (rst_mst),
        .adv_word (par_rd_go),
        .adv_bit  (1'b0),
        .slot     (rd_slot),
        .bit_idx  (rd_bit_unused)
    );

    ofs_reg_bank #(
        .HALF_W        (HALF_W),
        .DEF_EMPTY_OFS (DEF_EMPTY_OFS),
        .DEF_FULL_OFS  (DEF_FULL_OFS)
    ) u_bank (
        .clk       (clk),
        .rst_mst   (rst_mst),
        .par_wr_go (par_wr_go),
        .par_rd_go (par_rd_go),
        .ser_go    (ser_go),
        .ser_din   (ser_din),
        .wr_slot   (wr_slot),
        .wr_bit    (wr_bit),
        .rd_slot   (rd_slot),
        .pdata_in  (pdata_in),
        .ae_offset (ae_offset),
        .af_offset (af_offset),
        .pdata_out (pdata_out)
    );

endmodule

// File: rtl/ofs_flag_prog_chk.sv
module ofs_flag_prog_chk #(
    parameter int HALF_W = 9,
    parameter logic [2*HALF_W-1:0] DEF_EMPTY_OFS = 'h0007F,
    parameter logic [2*HALF_W-1:0] DEF_FULL_OFS  = 'h001FF
)(
    input logic                clk,
    input logic                rst_mst,
    input logic                rst_part,
    input logic                ser_en,
    input logic                load,
    input logic                wr_en,
    input logic                rd_en,
    input logic [2*HALF_W-1:0] ae_offset,
    input logic [2*HALF_W-1:0] af_offset,
    input logic [HALF_W-1:0]   pdata_out,
    input logic                access_err
);

    localparam int HW = HALF_W;

    AST_RESET_VALUES: assert property (@(posedge clk)
        rst_mst |=> (ae_offset == DEF_EMPTY_OFS) && (af_offset == DEF_FULL_OFS)
                    && (pdata_out == '0)); // R1

    AST_ERR_NEEDS_CLASH: assert property (@(posedge clk) disable iff (rst_mst)
        access_err |-> (load && wr_en && rd_en && !rst_part)); // R9

    AST_CLASH_NO_CHANGE: assert property (@(posedge clk) disable iff (rst_mst)
        (access_err && !ser_en) |=> ($stable(ae_offset) && $stable(af_offset)
                                     && $stable(pdata_out))); // R9

    AST_PART_RESET_INERT: assert property (@(posedge clk) disable iff (rst_mst)
        rst_part |=> ($stable(ae_offset) && $stable(af_offset)
                      && $stable(pdata_out))); // R10

    AST_READ_HOLDS_BUS: assert property (@(posedge clk) disable iff (rst_mst)
        !(load && rd_en && !wr_en) |=> $stable(pdata_out)); // R5

    AST_SHIFT_ONE_BIT: assert property (@(posedge clk) disable iff (rst_mst)
        (ser_en && !load) |=> ($countones({ae_offset ^ $past(ae_offset),
                                           af_offset ^ $past(af_offset)}) <= 1)); // R7

    AST_WRITE_ONE_HALF: assert property (@(posedge clk) disable iff (rst_mst)
        (load && wr_en && !rd_en && !ser_en) |=>
            ($countones({ae_offset[HW-1:0]      != $past(ae_offset[HW-1:0]),
                         ae_offset[2*HW-1:HW]   != $past(ae_offset[2*HW-1:HW]),
                         af_offset[HW-1:0]      != $past(af_offset[HW-1:0]),
                         af_offset[2*HW-1:HW]   != $past(af_offset[2*HW-1:HW])}) <= 1)); // R4

endmodule

bind ofs_flag_prog ofs_flag_prog_chk #(
    .HALF_W        (HALF_W),
    .DEF_EMPTY_OFS (DEF_EMPTY_OFS),
    .DEF_FULL_OFS  (DEF_FULL_OFS)
) u_chk (
    .clk        (clk),
    .rst_mst    (rst_mst),
    .rst_part   (rst_part),
    .ser_en     (ser_en),
    .load       (load),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .ae_offset  (ae_offset),
    .af_offset  (af_offset),
    .pdata_out  (pdata_out),
    .access_err (access_err)
);

// File: tb/tb_ofs_flag_prog.sv
`timescale 1ns/1ps
module tb_ofs_flag_prog;

    localparam logic [17:0] DEF_E = 18'h0007F;
    localparam logic [17:0] DEF_F = 18'h001FF;

    logic       clk = 1'b0;
    logic       rst_mst = 1'b1;
    logic       rst_part = 1'b0;
    logic       mode_ser_sel = 1'b0;
    logic       ser_en = 1'b0;
    logic       ser_din = 1'b0;
    logic       load = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [8:0] pdata_in = '0;
    logic [17:0] ae_offset;
    logic [17:0] af_offset;
    logic [8:0]  pdata_out;
    logic        access_err;

    int vectors = 0;
    int fails   = 0;

    // Reference model state
    logic [8:0] m_reg [4];
    int         m_wp = 0;
    int         m_rp = 0;
    int         m_bc = 0;
    bit         m_ser = 1'b0;
    bit         m_hold = 1'b1;
    logic [8:0] m_out = '0;

    always #2.5 clk = ~clk;

    ofs_flag_prog dut (
        .clk          (clk),
        .rst_mst      (rst_mst),
        .rst_part     (rst_part),
        .mode_ser_sel (mode_ser_sel),
        .ser_en       (ser_en),
        .ser_din      (ser_din),
        .load         (load),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .pdata_in     (pdata_in),
        .ae_offset    (ae_offset),
        .af_offset    (af_offset),
        .pdata_out    (pdata_out),
        .access_err   (access_err)
    );

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic cmp(input string tag, input string what, input logic [17:0] act,
                       input logic [17:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle right after a falling edge, check at the next falling edge.
    task automatic step(input string tag, input logic mr, input logic pr, input logic md,
                        input logic se, input logic sd, input logic ld, input logic we,
                        input logic re, input logic [8:0] din);
        bit clash;
        bit exp_err;
        rst_mst = mr; rst_part = pr; mode_ser_sel = md; ser_en = se; ser_din = sd;
        load = ld; wr_en = we; rd_en = re; pdata_in = din;
        clash   = ld && we && re;
        exp_err = 1'b0;
        if (mr) begin
            m_reg[0] = DEF_E[8:0]; m_reg[1] = DEF_E[17:9];
            m_reg[2] = DEF_F[8:0]; m_reg[3] = DEF_F[17:9];
            m_wp = 0; m_rp = 0; m_bc = 0; m_out = '0;
            m_ser = md; m_hold = 1'b1;
        end else if (m_hold) begin
            m_hold = 1'b0;
        end else if (!pr) begin
            exp_err = clash;
            if (!clash && ld && re) begin
                m_out = m_reg[m_rp];
                m_rp  = (m_rp + 1) % 4;
            end
            if (!clash && ld && we && !m_ser) begin
                m_reg[m_wp] = din;
                m_wp = (m_wp + 1) % 4;
            end
            if (se && m_ser) begin
                m_reg[m_wp][m_bc] = sd;
                m_bc++;
                if (m_bc == 9) begin
                    m_bc = 0;
                    m_wp = (m_wp + 1) % 4;
                end
            end
        end
        #1;
        cmp(tag, "access_err", {17'd0, access_err}, {17'd0, exp_err});
        @(posedge clk);
        @(negedge clk);
        cmp(tag, "ae_offset", ae_offset, {m_reg[1], m_reg[0]});
        cmp(tag, "af_offset", af_offset, {m_reg[3], m_reg[2]});
        cmp(tag, "pdata_out", {9'd0, pdata_out}, {9'd0, m_out});
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        @(negedge clk);
        // R1 reset values, parallel mode
        step("R1", 1, 0, 0, 0, 0, 0, 0, 0, 9'h000);
        step("R1", 1, 0, 0, 0, 0, 0, 0, 0, 9'h000);
        // R3 first cycle after reset ignores a write
        step("R3", 0, 0, 0, 0, 0, 1, 1, 0, 9'h155);
        // Parallel sweep: R4 R5 R6 R8 R9 R10, mode pin flipped for R2
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [8:0] d;
            op = (n * 7 + n / 5) % 6;
            d  = 9'((n * 73 + 5) & 9'h1FF);
            case (op)
                0: step("R6",  0, 0, 0, 0, 0, 0, 0, 0, d);
                1: step("R4",  0, 0, 0, 0, 0, 1, 1, 0, d);
                2: step("R5",  0, 0, 0, 0, 0, 1, 0, 1, d);
                3: step("R9",  0, 0, 0, 0, 0, 1, 1, 1, d);
                4: step("R10", 0, 1, 0, 1, 1, 1, n[0], ~n[0], d);
                default: step("R2_R8", 0, 0, 1, 1, n[1], 0, 0, 0, d);
            endcase
        end
        // Switch to serial mode
        step("R1", 1, 0, 1, 0, 0, 0, 0, 0, 9'h000);
        step("R3", 0, 0, 0, 1, 1, 0, 0, 0, 9'h000);
        for (int n = 0; n < 36 * 5; n++) begin
            logic sd;
            sd = logic'(((n * 5) >> 2) & 1) ^ logic'(n % 3 == 0);
            if (n % 13 == 0)      step("R9",  0, 0, 0, 1, sd, 1, 1, 1, 9'h0AA);
            else if (n % 11 == 0) step("R8",  0, 0, 0, 1, sd, 1, 1, 0, 9'h133);
            else if (n % 17 == 0) step("R10", 0, 1, 0, 1, sd, 1, 0, 1, 9'h000);
            else if (n % 7 == 0)  step("R5",  0, 0, 0, 1, sd, 1, 0, 1, 9'h000);
            else                  step("R7",  0, 0, 0, 1, sd, 0, 0, 0, 9'h000);
        end
        // R11 reset in the middle of a serial slot
        for (int n = 0; n < 5; n++) step("R7", 0, 0, 0, 1, 1, 0, 0, 0, 9'h000);
        step("R11", 1, 0, 1, 0, 0, 0, 0, 0, 9'h000);
        step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 9'h000);
        for (int n = 0; n < 9; n++) step("R11", 0, 0, 0, 1, n[0], 0, 0, 0, 9'h000);
        step("R11", 0, 0, 0, 0, 0, 1, 0, 1, 9'h000);
        // Back to parallel: full wrap of write then read pointers
        step("R2", 1, 0, 0, 0, 0, 0, 0, 0, 9'h000);
        step("R3", 0, 0, 1, 0, 0, 1, 0, 1, 9'h000);
        for (int n = 0; n < 6; n++) step("R4", 0, 0, 1, 0, 0, 1, 1, 0, 9'(9'h101 + n * 9'h11));
        for (int n = 0; n < 6; n++) step("R5", 0, 0, 1, 0, 0, 1, 0, 1, 9'h000);
        finish_up();
    end

endmodule